// File: doc/BRIEF.md
# Iterative Integer Power Unit

This block raises an integer base to an integer exponent and returns the result modulo 2^Y_W. It works by right-to-left square-and-multiply. The exponent is scanned from its least significant bit upward, one bit per clock. A running product is multiplied by the current base power whenever the scanned bit is set, and the base power is squared every cycle. Every product is truncated to the result width.

A single control input selects how the operands are read. In unsigned mode the base is zero-extended and the exponent is a plain magnitude. In signed mode both operands are two's complement, and the base is sign-extended. The exponent's top bit is still scanned as an ordinary bit. A negative exponent applied to a base whose magnitude exceeds one yields zero, because the true result would be a fraction. A negative exponent applied to 0, 1 or -1 returns whatever the bit scan produced.

A caller pulses `start` while the unit is idle. After a fixed number of clocks it sees a single-cycle `done`, with `y` valid and held until the next result.

The controller has three states:
- IDLE waits for `start`. On `start` it latches the operands and moves to RUN.
- RUN processes one exponent bit per cycle. It moves to FINISH after the last bit.
- FINISH applies the negative-exponent rule, registers `y`, raises `done`, and returns to IDLE.

Top module: `pow_unit`

## Requirements
- R1: After reset, `y` is 0, and `done` and `busy` are 0.
- R2: The A_W-bit base is extended to Y_W bits before use. It is zero-extended when `signed_mode` is 0 and sign-extended when `signed_mode` is 1. With A_W=6 and Y_W=8, base 0x3E to the power 1 gives 0x3E unsigned and 0xFE signed.
- R3: The running product starts at 1, so any base raised to exponent 0 gives 1. This includes base 0.
- R4: Every exponent bit from bit 0 to bit B_W-1 is visited in order. For each set bit, the running product is multiplied by the current base power, and the base power is squared after each bit. All products are truncated modulo 2^Y_W, so 2^8 gives 0 at Y_W=8.
- R5: In signed mode, when the exponent's top bit is 1 and the base's magnitude at A_W bits is greater than 1, `y` is 0. A base of -32 (0x20 at 6 bits) counts as magnitude 32.
- R6: In signed mode, a negative exponent with base 0, 1 or -1 returns the unmodified square-and-multiply result. For example, -1 with exponent 0xF gives 0xFF, and -1 with exponent 0xE gives 1.
- R7: `done` rises exactly B_W+1 clock edges after the edge that samples `start`. `busy` is high from the edge after `start` until `done` rises.
- R8: `done` is high for exactly one cycle, and `y` keeps its value until the next `done`.
- R9: `start` is ignored while `busy` is high. A second request during a run changes neither the run nor its result.
- R10: In unsigned mode the exponent's top bit is an ordinary magnitude bit and the zero rule never applies. For example, 3 with exponent 0xE gives 3^14 mod 256 = 0x79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled only in IDLE) |
| signed_mode | input | 1 | 1: operands are two's complement |
| base_a | input | A_W | Base operand |
| exp_b | input | B_W | Exponent operand |
| y | output | Y_W | Result, valid when `done` is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A computation is in progress |

## Verification
The hardest cases to reach from the ports are those that separate the negative-exponent zero rule from an ordinary wrap-around to zero.

Many bases with negative exponents truncate to 0 anyway, so they cannot show whether the rule fired. The stimulus therefore uses a base of 3 with exponent 0xE in both modes: the raw scan gives 0x79, so only the rule can produce 0 in signed mode. The exempt bases -1, 0 and 1 are covered with both odd and even negative exponents.

A second request injected mid-run shows that restarts are ignored. A reset asserted during RUN shows that the unit returns to idle.

// File: rtl/pow_pkg.sv
package pow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } pow_state_t;
endpackage

// File: rtl/pow_base_ext.sv
module pow_base_ext #(
    parameter int A_W = 6,
    parameter int Y_W = 8
) (
    input  logic [A_W-1:0] base_in,
    input  logic           sign_ext,
    output logic [Y_W-1:0] base_out
);
    generate
        if (Y_W > A_W) begin : g_widen
            logic fill;
            assign fill     = sign_ext & base_in[A_W-1];
            assign base_out = {{(Y_W-A_W){fill}}, base_in};
        end else begin : g_trunc
            logic unused_sign;
            assign unused_sign = sign_ext;
            assign base_out    = base_in[Y_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pow_trunc_mul.sv
module pow_trunc_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_z,
    output logic [W-1:0] prod
);
    logic [2*W-1:0] full;
    assign full = {{W{1'b0}}, op_x} * {{W{1'b0}}, op_z};
    assign prod = full[W-1:0];
endmodule

// File: rtl/pow_zero_rule.sv
module pow_zero_rule #(
    parameter int A_W = 6,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0] base_in,
    input  logic [B_W-1:0] exp_in,
    input  logic           signed_mode,
    output logic           force_zero
);
    logic [A_W-1:0] mag;
    logic           big_mag;

    always_comb begin
        mag     = base_in[A_W-1] ? (~base_in + A_W'(1)) : base_in;
        big_mag = (mag > A_W'(1));
    end

    assign force_zero = signed_mode & exp_in[B_W-1] & big_mag;
endmodule

// File: rtl/pow_unit.sv
module pow_unit #(
    parameter int A_W = 6,
    parameter int B_W = 4,
    parameter int Y_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [A_W-1:0] base_a,
    input  logic [B_W-1:0] exp_b,
    output logic [Y_W-1:0] y,
    output logic           done,
    output logic           busy
);
    import pow_pkg::*;

    localparam int IDX_W = (B_W > 1) ? $clog2(B_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(B_W - 1);

    pow_state_t     state, state_nx;
    logic [Y_W-1:0] acc, sq;
    logic [B_W-1:0] exp_q;
    logic [IDX_W-1:0] idx;
    logic           force_q;

    logic [Y_W-1:0] base_ext;
    logic [Y_W-1:0] acc_prod, sq_prod;
    logic           force_in;

    pow_base_ext #(.A_W(A_W), .Y_W(Y_W)) u_ext (
        .base_in (base_a),
        .sign_ext(signed_mode),
        .base_out(base_ext)
    );

    pow_zero_rule #(.A_W(A_W), .B_W(B_W)) u_rule (
        .base_in    (base_a),
        .exp_in     (exp_b),
        .signed_mode(signed_mode),
        .force_zero (force_in)
    );

    pow_trunc_mul #(.W(Y_W)) u_mul_acc (
        .op_x(acc),
        .op_z(sq),
        .prod(acc_prod)
    );

    pow_trunc_mul #(.W(Y_W)) u_mul_sq (
        .op_x(sq),
        .op_z(sq),
        .prod(sq_prod)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_RUN;
            ST_RUN:    if (idx == LAST_IDX) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            sq      <= '0;
            exp_q   <= '0;
            idx     <= '0;
            force_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    acc     <= Y_W'(1);
                    sq      <= base_ext;
                    exp_q   <= exp_b;
                    idx     <= '0;
                    force_q <= force_in;
                end
                ST_RUN: begin
                    if (exp_q[0]) acc <= acc_prod;
                    sq    <= sq_prod;
                    exp_q <= exp_q >> 1;
                    idx   <= idx + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y    <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_FINISH) begin
                y    <= force_q ? '0 : acc;
                done <= 1'b1;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    a_r3_acc_init: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (acc == Y_W'(1)));

    a_r9_idx_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idx != LAST_IDX) |=>
            (state == ST_RUN && idx == $past(idx) + IDX_W'(1)));

    a_r7_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_FINISH));

    a_r5_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && force_q) |=> (y == '0 && done));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FINISH) |=> $stable(y));
endmodule

// File: tb/pow_unit_tb_top.sv
module pow_unit_tb_top;
    localparam int A_W = 6;
    localparam int B_W = 4;
    localparam int Y_W = 8;
    localparam int NV  = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           signed_mode = 1'b0;
    logic [A_W-1:0] base_a = '0;
    logic [B_W-1:0] exp_b = '0;
    logic [Y_W-1:0] y;
    logic           done;
    logic           busy;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pow_unit #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .base_a(base_a), .exp_b(exp_b), .y(y), .done(done), .busy(busy)
    );

    // {signed, base, exp, expected}
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 6'h03, 4'h4, 8'h51},  // R4
        {1'b0, 6'h02, 4'h7, 8'h80},  // R4
        {1'b0, 6'h02, 4'h8, 8'h00},  // R4 truncation
        {1'b0, 6'h05, 4'h0, 8'h01},  // R3
        {1'b0, 6'h00, 4'h0, 8'h01},  // R3
        {1'b0, 6'h03, 4'hF, 8'h6B},  // R4 all bits
        {1'b0, 6'h3F, 4'h2, 8'h81},  // R2 zero ext
        {1'b0, 6'h3E, 4'h1, 8'h3E},  // R2
        {1'b1, 6'h3E, 4'h1, 8'hFE},  // R2 sign ext
        {1'b1, 6'h3E, 4'h3, 8'hF8},  // R2
        {1'b1, 6'h3D, 4'h2, 8'h09},  // R4
        {1'b1, 6'h02, 4'hF, 8'h00},  // R5
        {1'b1, 6'h03, 4'hE, 8'h00},  // R5
        {1'b0, 6'h03, 4'hE, 8'h79},  // R10
        {1'b1, 6'h3F, 4'hF, 8'hFF},  // R6
        {1'b1, 6'h01, 4'hD, 8'h01},  // R6
        {1'b1, 6'h00, 4'hF, 8'h00},  // R6
        {1'b1, 6'h20, 4'hF, 8'h00},  // R5
        {1'b1, 6'h03, 4'h6, 8'hD9},  // R4
        {1'b1, 6'h3F, 4'hE, 8'h01}   // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    // Returns cycles until done, or -1 on timeout
    task automatic run_op(input logic s, input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                          output int lat);
        @(negedge clk);
        signed_mode = s; base_a = a; exp_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (!done) lat = -1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 y", 32'(y), 32'h0);
        check("R1 done", 32'(done), 32'h0);
        check("R1 busy", 32'(busy), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][18], VEC[i][17:12], VEC[i][11:8], lat);
            check($sformatf("R4/R2/R3/R5/R6/R10 vec%0d", i), 32'(y), 32'(VEC[i][7:0]));
            check("R7 latency", 32'(lat), 32'(B_W + 1));
        end

        // R8: done single cycle and y held
        run_op(1'b0, 6'h03, 4'h4, lat);
        @(negedge clk);
        check("R8 done low", 32'(done), 32'h0);
        repeat (5) @(negedge clk);
        check("R8 y held", 32'(y), 32'h51);

        // R7: busy during run
        @(negedge clk);
        signed_mode = 1'b0; base_a = 6'h02; exp_b = 4'h3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy", 32'(busy), 32'h1);
        // R9: second request mid-run is ignored
        base_a = 6'h05; exp_b = 4'h2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check("R9 result", 32'(y), 32'h08);
        check("R9 latency", 32'(lat), 32'(B_W));
        @(negedge clk);
        check("R9 idle", 32'(busy), 32'h0);

        // R1: reset in the middle of a run
        @(negedge clk);
        base_a = 6'h03; exp_b = 4'hF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 busy mid-reset", 32'(busy), 32'h0);
        check("R1 done mid-reset", 32'(done), 32'h0);
        check("R1 y mid-reset", 32'(y), 32'h0);
        rst_n = 1'b1;
        run_op(1'b1, 6'h03, 4'hE, lat);
        check("R5 after reset", 32'(y), 32'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule